// File: doc/BRIEF.md
# Bus Activity and Idle Detector

This block sits behind the analog comparators of a differential-bus receiver. Three comparator flags come in: the magnitude of the differential level is above the activity threshold, the level is above the high-data threshold, and the level is below the low-data threshold. The block runs each flag through a synchroniser. It then declares the bus active or idle only after the activity flag has stayed in one state for a programmable number of clock cycles. A separate count applies to each direction. While the bus is active, the receive-enable output is driven low and the receive-data output follows the data thresholds, with a hold band between them. While the bus is idle, receive-enable is high and receive data is forced high.

For star topologies the block also filters the active-low transmit-enable pin and two active-low branch data lines into registered activity levels. Branch activity needs only one branch line low. Branch idle needs both lines high. All detection is held in the idle state while the device is outside normal power mode. The star detectors are also held idle while star mode is off. Every filter time is a parameter counted in clock cycles.

Top module: `bus_activity_detector`

## Requirements
- R1: After the synchronised activity flag has been high for BUS_ACT_CYC consecutive cycles, rx_en_n goes low. A flag driven high just after a clock edge gives rx_en_n low after exactly BUS_ACT_CYC+2 rising edges. There are two synchroniser stages ahead of the filter.
- R2: A single low cycle inside a run of the activity flag clears the qualification count. Two runs of BUS_ACT_CYC-1 cycles separated by one low cycle leave rx_en_n high.
- R3: While rx_en_n is low, rx_data goes to 1 when the high-data flag is set and to 0 when only the low-data flag is set. If both flags are set, the high flag wins. rx_data follows a flag change 3 rising edges after it is driven.
- R4: While rx_en_n is low and neither data flag is set, rx_data keeps its previous value.
- R5: After the activity flag has been low for BUS_IDLE_CYC consecutive synchronised cycles, rx_en_n returns high (BUS_IDLE_CYC+2 edges after the change). rx_data reads 1 whenever rx_en_n is high.
- R6: With star mode on, tx_active goes to 1 after txen_n has been low for TX_ACT_CYC synchronised cycles. It goes back to 0 after txen_n has been high for TX_IDLE_CYC cycles. Each change appears count+2 edges after the pin changes.
- R7: With star mode on, branch_active goes to 1 after at least one bit of branch_n has been low in each of BR_ACT_CYC consecutive synchronised cycles. The low bit may move from one line to the other during the run.
- R8: branch_active goes back to 0 only after both bits of branch_n have been high for BR_IDLE_CYC consecutive synchronised cycles. While either line stays low, it remains 1.
- R9: When op_normal is low at a rising edge, after that edge rx_en_n=1, rx_data=1, tx_active=0 and branch_active=0, and all counts clear. Once op_normal returns high with the activity flag already settled high, activity is declared after BUS_ACT_CYC more edges.
- R10: When star_mode is low at a rising edge, tx_active and branch_active are 0 after that edge, whatever the pins do.
- R11: While and after reset, rx_en_n=1, rx_data=1, tx_active=0 and branch_active=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_normal | input | 1 | High while the device is in a normal power mode (synchronous) |
| star_mode | input | 1 | High to enable the star-topology detectors (synchronous) |
| bus_above_act | input | 1 | Asynchronous comparator flag: differential magnitude above the activity threshold |
| bus_above_hi | input | 1 | Asynchronous comparator flag: differential level above the high-data threshold |
| bus_below_lo | input | 1 | Asynchronous comparator flag: differential level below the low-data threshold |
| txen_n | input | 1 | Asynchronous transmit-enable pin, active low |
| branch_n | input | 2 | Asynchronous star branch data lines, active low |
| rx_en_n | output | 1 | Receive enable, low while bus activity is declared |
| rx_data | output | 1 | Gated receive data, forced high while the bus is idle |
| tx_active | output | 1 | Transmit-enable activity level |
| branch_active | output | 1 | Branch line activity level |

## Verification
Any change on an asynchronous input spends two edges in the synchroniser. It then has to persist for the full filter count. A qualifier output therefore moves exactly count+2 rising edges after the input is driven, and a data-threshold change reaches rx_data after 3 edges. The mode inputs op_normal and star_mode are not synchronised and act at the very next edge. The bench drives on falling edges and samples on falling edges. For each qualification it checks the output one edge before the due edge, to see it unchanged, and again at the due edge, to see it changed. This pins the latency to the exact cycle rather than to a window.

// File: rtl/bd_pkg.sv
// Package: shared constants and helpers for the bus activity detector.
// Assumes: all cycle counts given to cnt_width are at least 1.
package bd_pkg;

    // Bit positions inside the synchronised input vector.
    localparam int SIX_ABOVE = 0;
    localparam int SIX_HI    = 1;
    localparam int SIX_LO    = 2;
    localparam int SIX_TXEN  = 3;
    localparam int SIX_BR0   = 4;
    localparam int SIX_BR1   = 5;
    localparam int SYNC_W    = 6;

    // Reset value: comparators quiet, active-low pins released (high).
    localparam logic [SYNC_W-1:0] SYNC_RST = 6'b111000;

    // Counter width able to hold values 0 .. max(a,b)-1.
    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/bd_sync.sv
// Module: bd_sync
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes: bits are unrelated (no multi-bit coherence required).
module bd_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture stage then settle stage, both reset to the idle pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/bd_qual.sv
// Module: bd_qual
// Two-state activity qualifier. In idle it counts consecutive cycles with
// cond high and turns active after ACT_CYC of them; in active it counts
// consecutive cycles with cond low and turns idle after IDLE_CYC of them.
// A broken run clears the count. en low forces idle and clears the count.
// Assumes: cond is already synchronous; ACT_CYC and IDLE_CYC are >= 1.
module bd_qual
    import bd_pkg::*;
#(
    parameter int ACT_CYC  = 8,
    parameter int IDLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cond,
    output logic active
);

    localparam int            CW        = cnt_width(ACT_CYC, IDLE_CYC);
    localparam logic [CW-1:0] ACT_LAST  = CW'(ACT_CYC - 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_CYC - 1);

    logic [CW-1:0] run_cnt;
    logic          act_q;
    logic          toward;
    logic [CW-1:0] last_val;

    // A cycle counts toward a change when cond disagrees with the state.
    always_comb begin
        toward   = (cond != act_q);
        last_val = act_q ? IDLE_LAST : ACT_LAST;
    end

    // Run counter and state flip on a completed qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            act_q   <= 1'b0;
        end else if (!en) begin
            run_cnt <= '0;
            act_q   <= 1'b0;
        end else if (toward) begin
            if (run_cnt == last_val) begin
                run_cnt <= '0;
                act_q   <= ~act_q;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/bd_rx_gate.sv
// Module: bd_rx_gate
// Receive-data path: tracks the high/low data thresholds with a hold band
// (neither flag set keeps the last level; both set resolves high) and
// forces the output high whenever the bus is not declared active.
// Assumes: flags are synchronous; en low means outside normal power mode.
module bd_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic above_hi,
    input  logic below_lo,
    input  logic bus_active,
    output logic rx_data
);

    logic level_q;

    // Data level register with hold band; returns high outside normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b1;
        end else if (!en) begin
            level_q <= 1'b1;
        end else if (above_hi) begin
            level_q <= 1'b1;
        end else if (below_lo) begin
            level_q <= 1'b0;
        end
    end

    // Output gate: idle bus blocks data and reads high.
    always_comb begin
        rx_data = bus_active ? level_q : 1'b1;
    end

endmodule

// File: rtl/bus_activity_detector.sv
// Module: bus_activity_detector (top)
// Synchronises comparator flags and star pins, qualifies bus activity/idle
// into an active-low receive enable with gated receive data, and qualifies
// transmit-enable and branch activity for star topologies.
// Assumes: op_normal and star_mode are synchronous to clk; all cycle
// parameters are >= 1.
module bus_activity_detector
    import bd_pkg::*;
#(
    parameter int BUS_ACT_CYC  = 8,
    parameter int BUS_IDLE_CYC = 12,
    parameter int TX_ACT_CYC   = 4,
    parameter int TX_IDLE_CYC  = 6,
    parameter int BR_ACT_CYC   = 5,
    parameter int BR_IDLE_CYC  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_normal,
    input  logic       star_mode,
    input  logic       bus_above_act,
    input  logic       bus_above_hi,
    input  logic       bus_below_lo,
    input  logic       txen_n,
    input  logic [1:0] branch_n,
    output logic       rx_en_n,
    output logic       rx_data,
    output logic       tx_active,
    output logic       branch_active
);

    localparam int STAR_N = 2;
    localparam int STAR_ACT [STAR_N]  = '{TX_ACT_CYC,  BR_ACT_CYC};
    localparam int STAR_IDLE[STAR_N]  = '{TX_IDLE_CYC, BR_IDLE_CYC};

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_vec;
    logic              s_above;
    logic              s_hi;
    logic              s_lo;
    logic              s_txen_n;
    logic [1:0]        s_branch_n;
    logic              bus_act;
    logic              star_en;
    logic [STAR_N-1:0] star_cond;
    logic [STAR_N-1:0] star_act;

    // Pack asynchronous inputs into the synchroniser vector.
    always_comb begin
        raw_vec            = '0;
        raw_vec[SIX_ABOVE] = bus_above_act;
        raw_vec[SIX_HI]    = bus_above_hi;
        raw_vec[SIX_LO]    = bus_below_lo;
        raw_vec[SIX_TXEN]  = txen_n;
        raw_vec[SIX_BR0]   = branch_n[0];
        raw_vec[SIX_BR1]   = branch_n[1];
    end

    bd_sync #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (sync_vec)
    );

    // Unpack synchronised inputs and form the star qualifier conditions.
    always_comb begin
        s_above      = sync_vec[SIX_ABOVE];
        s_hi         = sync_vec[SIX_HI];
        s_lo         = sync_vec[SIX_LO];
        s_txen_n     = sync_vec[SIX_TXEN];
        s_branch_n   = {sync_vec[SIX_BR1], sync_vec[SIX_BR0]};
        star_en      = op_normal & star_mode;
        star_cond[0] = ~s_txen_n;
        star_cond[1] = ~(&s_branch_n);
    end

    bd_qual #(
        .ACT_CYC  (BUS_ACT_CYC),
        .IDLE_CYC (BUS_IDLE_CYC)
    ) i_bus_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (op_normal),
        .cond   (s_above),
        .active (bus_act)
    );

    bd_rx_gate i_rx_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (op_normal),
        .above_hi   (s_hi),
        .below_lo   (s_lo),
        .bus_active (bus_act),
        .rx_data    (rx_data)
    );

    // One qualifier per star input group: transmit enable, then branches.
    for (genvar g = 0; g < STAR_N; g++) begin : g_star
        bd_qual #(
            .ACT_CYC  (STAR_ACT[g]),
            .IDLE_CYC (STAR_IDLE[g])
        ) i_star_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (star_en),
            .cond   (star_cond[g]),
            .active (star_act[g])
        );
    end

    assign rx_en_n       = ~bus_act;
    assign tx_active     = star_act[0];
    assign branch_active = star_act[1];

endmodule

// File: rtl/bd_checker.sv
// Module: bd_checker
// Temporal properties of bus_activity_detector, attached by bind.
module bd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       op_normal,
    input logic       star_mode,
    input logic       rx_en_n,
    input logic       rx_data,
    input logic       tx_active,
    input logic       branch_active,
    input logic       above_s,
    input logic       hi_s,
    input logic       lo_s,
    input logic [1:0] br_s
);

    // R1: activity can only be declared on a cycle the flag was high.
    a_r1_act_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_en_n) |-> $past(above_s));

    // R4: hold band keeps rx_data while active.
    a_r4_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_n && $past(!rx_en_n) && $past(op_normal) &&
         !$past(hi_s) && !$past(lo_s)) |-> $stable(rx_data));

    // R5: an idle bus always reads high.
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_n |-> rx_data);

    // R7: branch activity starts only on a cycle with a branch line low.
    a_r7_branch_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(branch_active) |-> $past(!(&br_s)));

    // R8: branch idle in star normal mode needs both lines high.
    a_r8_branch_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(branch_active) && $past(op_normal) && $past(star_mode))
            |-> $past(&br_s));

    // R9: leaving normal mode drops every indication at the next edge.
    a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        !op_normal |=> (rx_en_n && rx_data && !tx_active && !branch_active));

    // R10: star mode off clears the star indications.
    a_r10_star_off: assert property (@(posedge clk) disable iff (!rst_n)
        !star_mode |=> (!tx_active && !branch_active));

endmodule

bind bus_activity_detector bd_checker i_bd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_normal     (op_normal),
    .star_mode     (star_mode),
    .rx_en_n       (rx_en_n),
    .rx_data       (rx_data),
    .tx_active     (tx_active),
    .branch_active (branch_active),
    .above_s       (s_above),
    .hi_s          (s_hi),
    .lo_s          (s_lo),
    .br_s          (s_branch_n)
);

// File: tb/test_bus_activity_detector.sv
module test_bus_activity_detector;

    localparam int BA = 8;
    localparam int BI = 12;
    localparam int TA = 4;
    localparam int TI = 6;
    localparam int RA = 5;
    localparam int RI = 7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_normal;
    logic       star_mode;
    logic       above;
    logic       hi;
    logic       lo;
    logic       txen_n;
    logic [1:0] br_n;
    logic       rx_en_n;
    logic       rx_data;
    logic       tx_active;
    logic       branch_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    bus_activity_detector #(
        .BUS_ACT_CYC (BA), .BUS_IDLE_CYC (BI),
        .TX_ACT_CYC  (TA), .TX_IDLE_CYC  (TI),
        .BR_ACT_CYC  (RA), .BR_IDLE_CYC  (RI)
    ) i_bus_activity_detector (
        .clk (clk), .rst_n (rst_n), .op_normal (op_normal),
        .star_mode (star_mode), .bus_above_act (above),
        .bus_above_hi (hi), .bus_below_lo (lo), .txen_n (txen_n),
        .branch_n (br_n), .rx_en_n (rx_en_n), .rx_data (rx_data),
        .tx_active (tx_active), .branch_active (branch_active)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();  // R11
        rst_n = 1'b0; op_normal = 1'b1; star_mode = 1'b1;
        above = 1'b0; hi = 1'b0; lo = 1'b0; txen_n = 1'b1; br_n = 2'b11;
        cyc(3);
        chk("R11", "rx_en_n in reset", rx_en_n, 1'b1);
        chk("R11", "rx_data in reset", rx_data, 1'b1);
        chk("R11", "tx_active in reset", tx_active, 1'b0);
        chk("R11", "branch_active in reset", branch_active, 1'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R11", "rx_en_n after reset", rx_en_n, 1'b1);
    endtask

    task automatic t_broken_run();  // R2
        above = 1'b1; cyc(BA - 1);
        above = 1'b0; cyc(1);
        above = 1'b1; cyc(BA - 1);
        above = 1'b0; cyc(4);
        chk("R2", "broken run stays idle", rx_en_n, 1'b1);
    endtask

    task automatic t_activity();  // R1
        above = 1'b1;
        cyc(BA + 1);
        chk("R1", "rx_en_n one edge early", rx_en_n, 1'b1);
        cyc(1);
        chk("R1", "rx_en_n at due edge", rx_en_n, 1'b0);
    endtask

    task automatic t_data();  // R3, R4
        chk("R3", "rx_data on activity", rx_data, 1'b1);
        lo = 1'b1; cyc(2);
        chk("R3", "rx_data before low latency", rx_data, 1'b1);
        cyc(1);
        chk("R3", "rx_data low", rx_data, 1'b0);
        lo = 1'b0; cyc(5);
        chk("R4", "hold band keeps low", rx_data, 1'b0);
        hi = 1'b1; cyc(3);
        chk("R3", "rx_data high", rx_data, 1'b1);
        hi = 1'b0; cyc(5);
        chk("R4", "hold band keeps high", rx_data, 1'b1);
        hi = 1'b1; lo = 1'b1; cyc(3);
        chk("R3", "both flags resolve high", rx_data, 1'b1);
        hi = 1'b0; cyc(3);
        chk("R3", "low flag alone", rx_data, 1'b0);
    endtask

    task automatic t_idle();  // R5
        above = 1'b0;
        cyc(BI + 1);
        chk("R5", "rx_en_n one edge before idle", rx_en_n, 1'b0);
        chk("R5", "rx_data still passes low", rx_data, 1'b0);
        cyc(1);
        chk("R5", "rx_en_n at idle", rx_en_n, 1'b1);
        chk("R5", "rx_data forced high", rx_data, 1'b1);
        lo = 1'b0;
    endtask

    task automatic t_txen();  // R6
        txen_n = 1'b0; cyc(TA + 1);
        chk("R6", "tx_active one edge early", tx_active, 1'b0);
        cyc(1);
        chk("R6", "tx_active set", tx_active, 1'b1);
        txen_n = 1'b1; cyc(TI + 1);
        chk("R6", "tx_active held before idle", tx_active, 1'b1);
        cyc(1);
        chk("R6", "tx_active cleared", tx_active, 1'b0);
    endtask

    task automatic t_branch();  // R7, R8
        br_n = 2'b10; cyc(2);
        br_n = 2'b01; cyc(RA - 1);
        chk("R7", "branch_active one edge early", branch_active, 1'b0);
        cyc(1);
        chk("R7", "branch_active on either line low", branch_active, 1'b1);
        br_n = 2'b10; cyc(RI + 4);
        chk("R8", "one line low keeps activity", branch_active, 1'b1);
        br_n = 2'b11; cyc(RI + 1);
        chk("R8", "branch_active before idle", branch_active, 1'b1);
        cyc(1);
        chk("R8", "branch idle on both high", branch_active, 1'b0);
    endtask

    task automatic t_mode_off();  // R9
        txen_n = 1'b0; above = 1'b1; cyc(BA + TA + 4);
        chk("R9", "setup bus active", rx_en_n, 1'b0);
        chk("R9", "setup tx active", tx_active, 1'b1);
        op_normal = 1'b0; cyc(1);
        chk("R9", "rx_en_n released", rx_en_n, 1'b1);
        chk("R9", "rx_data high", rx_data, 1'b1);
        chk("R9", "tx_active cleared", tx_active, 1'b0);
        cyc(BA + 4);
        chk("R9", "stays idle with flag high", rx_en_n, 1'b1);
        op_normal = 1'b1; cyc(BA - 1);
        chk("R9", "requalify one edge early", rx_en_n, 1'b1);
        cyc(1);
        chk("R9", "requalify at due edge", rx_en_n, 1'b0);
    endtask

    task automatic t_star_off();  // R10
        cyc(TA + 2);
        chk("R10", "setup tx active", tx_active, 1'b1);
        star_mode = 1'b0; cyc(1);
        chk("R10", "tx_active cleared", tx_active, 1'b0);
        br_n = 2'b00; cyc(RA + 4);
        chk("R10", "branch ignored", branch_active, 1'b0);
        chk("R10", "tx ignored", tx_active, 1'b0);
        chk("R10", "bus unaffected", rx_en_n, 1'b0);
    endtask

    initial begin
        t_reset();
        t_broken_run();
        t_activity();
        t_data();
        t_idle();
        t_txen();
        t_branch();
        t_mode_off();
        t_star_off();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule